// File: doc/BRIEF.md
# Watchdog-capable OS timer core

This block is an operating-system timer. It keeps one 32-bit counter that steps up by one on every clock cycle in which the tick-enable input is high. A set of match channels (four by default) each hold a 32-bit compare value. When a counter step lands exactly on a channel's compare value and that channel's interrupt enable is set, the block latches a status flag for the channel. The channel's interrupt line is driven from that flag. Software clears a flag by writing a 1 to its position in the status register.

The highest match channel can also serve as a one-shot watchdog. If bit 0 of the watchdog-enable register is set when that channel matches, the block pulses a reset-request output for one cycle. In the same clock edge it clears the watchdog-enable register, so software has to re-arm it before another reset can be requested. All state is reached through a plain 32-bit register bus. Reads are combinational, so the data belongs to the address presented in the same cycle. Writes take effect on the next rising clock edge.

Top module: `os_timer_core`

## Requirements
- R1: While tick_en is high and the counter is not being written, the counter (offset 0x10) increases by one at each rising edge, wrapping from 0xFFFFFFFF to 0. With tick_en low, it holds its value.
- R2: A bus write to offset 0x10 loads the counter with the written value, even in a cycle where tick_en is high. Counting then continues from the loaded value.
- R3: Match values for channels 0 to 3 live at offsets 0x00, 0x04, 0x08 and 0x0C. When a tick step makes the counter equal to match value N and interrupt-enable bit N is 1, status bit N and irq[N] become 1 at that same rising edge. A counter load that makes the counter equal to a match value is not a match. The flag is set once per equality event, and it stays set until it is cleared.
- R4: When interrupt-enable bit N is 0, a match on channel N leaves status bit N and irq[N] at 0.
- R5: Writing the status register (offset 0x14) clears each bit written as 1, which also drops that bit's irq line, and leaves bits written as 0 unchanged. A match in the same cycle as the clear keeps its bit set.
- R6: The interrupt-enable register (offset 0x1C) stores only bits 11:0. Bits 31:12 read as 0.
- R7: When channel 3 matches and bit 0 of the watchdog-enable register (offset 0x18) is 1, reset_req is high for exactly one cycle, and the register reads 0 afterwards. This does not depend on the interrupt-enable register. With bit 0 clear, no reset is requested and the register keeps its value.
- R8: Every defined register reads back its current value on bus_rdata, combinationally, during a read cycle.
- R9: After reset, the counter, all match registers, status, interrupt enable and watchdog enable read 0, irq is 0 and reset_req is 0.
- R10: Reads of undefined offsets, including misaligned ones, return 0. Writes to undefined offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Counter advance enable for this cycle |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational, 0 when not reading) |
| irq | output | 4 | Per-channel interrupt lines |
| reset_req | output | 1 | One-cycle system reset request from the watchdog |

## Verification
The match path is swept over every channel, with its enable bit both set and clear. The counter is stepped up to the compare value and past it, which separates a correct match from a match that fires one tick early, one tick late, fires again, or ignores the enable bit. A wrap-around match at zero, a counter load directly onto the compare value, and two channels matching at the same tick test the edge cases of equality detection and show whether clearing one flag leaves the other alone. A clear written in the same cycle as a new match, and watchdog runs with bit 0 set, with bit 0 clear, and re-run after the one-shot clear, separate set-versus-clear priority from the reset-request behaviour.

// File: rtl/ostmr_pkg.sv
package ostmr_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 8;
    localparam int NCH      = 4;
    localparam int IE_W     = 12;
    localparam int WDOG_CH  = NCH - 1;

    localparam logic [ADDR_W-1:0] OFF_MATCH0 = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_COUNT  = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_STATUS = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_WDOG   = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_IEN    = 8'h1C;

    typedef struct packed {
        logic [NCH-1:0]    status;
        logic [IE_W-1:0]   ien;
        logic [DATA_W-1:0] wdog;
        logic              rst_req;
    } ctrl_state_t;

    function automatic logic [ADDR_W-1:0] match_off(input int idx);
        return OFF_MATCH0 + ADDR_W'(4 * idx);
    endfunction
endpackage

// File: rtl/ostmr_counter.sv
module ostmr_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic [W-1:0] count_next,
    output logic         step
);
    logic [W-1:0] count_d, count_q;

    assign count_next = count_q + W'(1);
    assign step       = tick && !load;

    always_comb begin
        count_d = count_q;
        if (load)
            count_d = load_val;
        else if (tick)
            count_d = count_next;
    end

    always_ff @(posedge clk) begin
        if (rst) count_q <= '0;
        else     count_q <= count_d;
    end

    assign count = count_q;

    assert_count_step_R1: assert property (@(posedge clk) disable iff (rst)
        (tick && !load) |=> (count_q == $past(count_q) + W'(1)));
    assert_count_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(count_q));
    assert_count_load_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> (count_q == $past(load_val)));
endmodule

// File: rtl/ostmr_match_chan.sv
module ostmr_match_chan #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] wdata,
    input  logic         step,
    input  logic [W-1:0] count_next,
    output logic [W-1:0] match_val,
    output logic         hit
);
    logic [W-1:0] match_d, match_q;

    always_comb begin
        match_d = match_q;
        if (we) match_d = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) match_q <= '0;
        else     match_q <= match_d;
    end

    assign match_val = match_q;
    assign hit       = step && (count_next == match_q);
endmodule

// File: rtl/os_timer_core.sv
module os_timer_core
    import ostmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NCH-1:0]    irq,
    output logic              reset_req
);
    logic              wr_en, rd_en;
    logic [DATA_W-1:0] count, count_next;
    logic              step;
    logic [NCH-1:0]    hits;
    logic [NCH-1:0]    match_we;
    logic [DATA_W-1:0] match_val [NCH];
    ctrl_state_t       st_d, st_q;

    assign wr_en = bus_sel && bus_wr;
    assign rd_en = bus_sel && !bus_wr;

    ostmr_counter #(.W(DATA_W)) u_counter (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick_en),
        .load       (wr_en && bus_addr == OFF_COUNT),
        .load_val   (bus_wdata),
        .count      (count),
        .count_next (count_next),
        .step       (step)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        assign match_we[i] = wr_en && (bus_addr == match_off(i));
        ostmr_match_chan #(.W(DATA_W)) u_chan (
            .clk        (clk),
            .rst        (rst),
            .we         (match_we[i]),
            .wdata      (bus_wdata),
            .step       (step),
            .count_next (count_next),
            .match_val  (match_val[i]),
            .hit        (hits[i])
        );
    end

    always_comb begin
        st_d         = st_q;
        st_d.rst_req = 1'b0;
        if (wr_en && bus_addr == OFF_STATUS)
            st_d.status = st_q.status & ~bus_wdata[NCH-1:0];
        if (wr_en && bus_addr == OFF_IEN)
            st_d.ien = bus_wdata[IE_W-1:0];
        if (wr_en && bus_addr == OFF_WDOG)
            st_d.wdog = bus_wdata;
        st_d.status = st_d.status | (hits & st_q.ien[NCH-1:0]);
        if (hits[WDOG_CH] && st_q.wdog[0]) begin
            st_d.rst_req = 1'b1;
            st_d.wdog    = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            case (bus_addr)
                OFF_COUNT:  bus_rdata = count;
                OFF_STATUS: bus_rdata = DATA_W'(st_q.status);
                OFF_WDOG:   bus_rdata = st_q.wdog;
                OFF_IEN:    bus_rdata = DATA_W'(st_q.ien);
                default: begin
                    for (int i = 0; i < NCH; i++)
                        if (bus_addr == match_off(i)) bus_rdata = match_val[i];
                end
            endcase
        end
    end

    assign irq       = st_q.status;
    assign reset_req = st_q.rst_req;

    assert_flag_needs_ien_R4: assert property (@(posedge clk) disable iff (rst)
        ((st_q.status & ~$past(st_q.status) & ~$past(st_q.ien[NCH-1:0])) == '0));
    assert_w1c_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && bus_addr == OFF_STATUS)
        |=> ((st_q.status & $past(bus_wdata[NCH-1:0]) & ~$past(hits)) == '0));
    assert_rstreq_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        st_q.rst_req |=> !st_q.rst_req);
    assert_rstreq_disarms_R7: assert property (@(posedge clk) disable iff (rst)
        st_q.rst_req |-> (st_q.wdog == '0));
    assert_rstreq_cause_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.rst_req) |-> $past(hits[WDOG_CH] && st_q.wdog[0]));
endmodule

// File: tb/test_os_timer_core.sv
module test_os_timer_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq;
    logic        reset_req;

    int checks = 0;
    int failures = 0;
    int rr_pulses = 0;
    int cycles = 0;

    os_timer_core i_os_timer_core (
        .clk(clk), .rst(rst), .tick_en(tick_en), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .reset_req(reset_req)
    );

    always #2.5 clk = ~clk;

    always @(negedge clk) begin
        cycles++;
        if (reset_req) rr_pulses++;
        if (cycles > 20000) begin
            failures++;
            checks++;
            $display("FAIL watchdog: run hung, actual=%0d expected<20000 cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    logic [31:0] v;
    logic [31:0] base;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9 reset state, R8 readback
        for (int a = 0; a < 8; a++) begin
            rd(8'(a * 4), v);
            check("R9 reset register", v, 32'h0);
        end
        check("R9 reset irq", {28'h0, irq}, 32'h0);
        check("R9 reset reset_req", {31'h0, reset_req}, 32'h0);

        // R2 load, R1 counting
        wr(8'h10, 32'h0000_1234);
        rd(8'h10, v); check("R2 counter load", v, 32'h1234);
        ticks(5);
        rd(8'h10, v); check("R1 counter steps", v, 32'h1239);
        rd(8'h10, v); check("R1 counter holds", v, 32'h1239);

        // R2 load wins over tick in the same cycle
        @(negedge clk);
        tick_en = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h10; bus_wdata = 32'h500;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        @(negedge clk);
        tick_en = 1'b0;
        rd(8'h10, v); check("R2 load beats tick then counts", v, 32'h501);

        // R6 interrupt enable width
        wr(8'h1C, 32'hFFFF_FFFF);
        rd(8'h1C, v); check("R6 ien keeps 12 bits", v, 32'h0000_0FFF);

        // R3/R4 sweep over channels and enable
        for (int ch = 0; ch < 4; ch++) begin
            for (int en = 0; en < 2; en++) begin
                base = 32'(ch * 100 + en * 40 + 10);
                for (int k = 0; k < 4; k++) wr(8'(k * 4), 32'hF000_0000);
                wr(8'(ch * 4), base + 3);
                rd(8'(ch * 4), v); check("R8 match readback", v, base + 3);
                wr(8'h1C, en ? (32'h1 << ch) : 32'h0);
                wr(8'h14, 32'hF);
                wr(8'h10, base);
                ticks(2);
                rd(8'h14, v); check("R3 no early match", v, 32'h0);
                ticks(1);
                rd(8'h14, v);
                if (en) check("R3 match sets status", v, 32'h1 << ch);
                else    check("R4 disabled no status", v, 32'h0);
                check(en ? "R3 irq raised" : "R4 irq stays low", {28'h0, irq},
                      en ? (32'h1 << ch) : 32'h0);
                ticks(3);
                rd(8'h14, v); check(en ? "R3 flag sticky" : "R4 still clear", v,
                                    en ? (32'h1 << ch) : 32'h0);
                wr(8'h14, 32'h1 << ch);
                rd(8'h14, v); check("R5 w1c clears", v, 32'h0);
                check("R5 irq dropped", {28'h0, irq}, 32'h0);
                ticks(4);
                rd(8'h14, v); check("R3 once per equality", v, 32'h0);
            end
        end

        // R1 wrap and R3 match at zero
        wr(8'h00, 32'h0);
        wr(8'h1C, 32'h1);
        wr(8'h10, 32'hFFFF_FFFF);
        ticks(1);
        rd(8'h10, v); check("R1 wrap to zero", v, 32'h0);
        rd(8'h14, v); check("R3 match on wrap", v, 32'h1);
        wr(8'h14, 32'hF);

        // R3 load onto match value is no match
        wr(8'h00, 32'h777);
        wr(8'h10, 32'h777);
        rd(8'h14, v); check("R3 load is not a match", v, 32'h0);
        ticks(2);
        rd(8'h14, v); check("R3 ticks past loaded equal", v, 32'h0);

        // R5 selective clear with two channels matching together
        wr(8'h00, 32'h900); wr(8'h04, 32'h900);
        wr(8'h1C, 32'h3);
        wr(8'h10, 32'h8FF);
        ticks(1);
        rd(8'h14, v); check("R3 two channels same tick", v, 32'h3);
        wr(8'h14, 32'h1);
        rd(8'h14, v); check("R5 bit written 0 kept", v, 32'h2);
        check("R5 irq per channel", {28'h0, irq}, 32'h2);

        // R5 set wins over clear in the same cycle
        wr(8'h14, 32'hF);
        wr(8'h00, 32'hA00);
        wr(8'h1C, 32'h1);
        wr(8'h10, 32'h9FF);
        @(negedge clk);
        tick_en = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h14; bus_wdata = 32'hF;
        @(negedge clk);
        tick_en = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        rd(8'h14, v); check("R5 match beats clear", v, 32'h1);
        wr(8'h14, 32'hF);

        // R7 watchdog, independent of ien
        wr(8'h1C, 32'h0);
        wr(8'h0C, 32'hB00);
        wr(8'h18, 32'h1);
        rd(8'h18, v); check("R8 wdog readback", v, 32'h1);
        rr_pulses = 0;
        wr(8'h10, 32'hAFE);
        ticks(2);
        repeat (2) @(negedge clk);
        check("R7 one reset pulse", 32'(rr_pulses), 32'd1);
        rd(8'h18, v); check("R7 wdog self clears", v, 32'h0);
        rd(8'h14, v); check("R4 wdog match no status", v, 32'h0);
        rr_pulses = 0;
        wr(8'h10, 32'hAFE);
        ticks(3);
        check("R7 disarmed no reset", 32'(rr_pulses), 32'd0);
        wr(8'h18, 32'h2);
        wr(8'h10, 32'hAFE);
        ticks(3);
        check("R7 bit0 clear no reset", 32'(rr_pulses), 32'd0);
        rd(8'h18, v); check("R7 wdog kept without bit0", v, 32'h2);

        // R10 undefined offsets
        wr(8'h20, 32'hDEAD_BEEF);
        rd(8'h20, v); check("R10 undefined reads zero", v, 32'h0);
        wr(8'h01, 32'h1234_5678);
        rd(8'h01, v); check("R10 misaligned reads zero", v, 32'h0);
        rd(8'h00, v); check("R10 match0 untouched", v, 32'hA00);
        rd(8'h18, v); check("R10 wdog untouched", v, 32'h2);
        rd(8'h10, v); check("R10 counter untouched", v, 32'hB01);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule